// File: doc/BRIEF.md
# Host Byte Port

This block lets an external microprocessor exchange single bytes with on-chip logic over an 8-bit parallel bus. The host controls it with three active-low strobes (select, read, write) that have no timing relation to the internal clock. To the host the port looks like one byte location. A host write fills an inbound byte register. A host read returns an outbound byte register that the on-chip side loaded earlier.

On the internal side a synchronous interface offers the following. A one-cycle pulse loads the outbound register. A pulse acknowledges the inbound byte, which stays visible on a read-data output. Separate pulses clear the interrupt and overflow flags. The block reports inbound-full, outbound-full, overflow and an interrupt request.

An enable input chooses between port operation and plain I/O. While it is low the strobes have no effect. Each strobe passes through a two-stage synchronizer. The end of each qualified access is detected on the synchronized copies, and every flag update is taken from that event.

Top module: `host_byte_port`

## Requirements
- R1: After reset the inbound-full, outbound-full, overflow and interrupt outputs are 0, and the bus output enable is 0.
- R2: While `port_en` is 0 the strobes are ignored: no flag changes, the inbound register keeps its value and `ext_data_oe` stays 0.
- R3: `ext_data_oe` is 1 exactly while `port_en` is 1 and both `ext_cs_n` and `ext_rd_n` are low. While it is 1, `ext_data_out` carries the outbound register.
- R4: A host write begins at the first synchronized sample with select and write both low. It ends when either of them returns high. At the end the bus value is loaded into the inbound register (`cpu_rdata`) and `in_full` is set, no later than 4 clocks after the release. The host keeps the bus value stable for at least 4 clocks after the release.
- R5: A `cpu_rd_in` pulse clears `in_full`. If it coincides with the end of a host write, the flag ends up set.
- R6: A host write that ends while `in_full` is 1 and no `cpu_rd_in` is present in that cycle sets `overflow`. The flag is sticky until a `cpu_clr_ovf` pulse.
- R7: A `cpu_wr_out` pulse loads `cpu_wdata` into the outbound register and sets `out_full`. The end of a host read (select or read returning high) clears `out_full`, unless a load happens in the same cycle.
- R8: The end of any qualified host access sets `irq` one clock after it is detected. `irq` stays 1 until a `cpu_clr_irq` pulse, and a new access end in that cycle wins.
- R9: A write or read strobe that goes low while `ext_cs_n` is high starts no access. No flag changes and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | 1 = port function, 0 = plain I/O |
| ext_cs_n | input | 1 | Host select, active low, asynchronous |
| ext_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| ext_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| ext_data_in | input | 8 | Bus value presented by the host |
| ext_data_out | output | 8 | Bus value returned to the host |
| ext_data_oe | output | 1 | Bus drive enable; 0 means high impedance |
| cpu_wr_out | input | 1 | Pulse: load outbound register |
| cpu_wdata | input | 8 | Data for the outbound register |
| cpu_rd_in | input | 1 | Pulse: acknowledge the inbound byte |
| cpu_rdata | output | 8 | Inbound register contents |
| cpu_clr_irq | input | 1 | Pulse: clear the interrupt flag |
| cpu_clr_ovf | input | 1 | Pulse: clear the overflow flag |
| in_full | output | 1 | Inbound byte not yet acknowledged |
| out_full | output | 1 | Outbound byte not yet read by the host |
| overflow | output | 1 | Sticky: a host write replaced an unacknowledged byte |
| irq | output | 1 | Interrupt request |

## Verification
Host writes use distinct byte values, so a stale register or a missed load shows up as a wrong value rather than a matching one. A second write with no acknowledgment in between separates the overflow path from the normal one. Strobe patterns with the enable low, and with select high but read or write low, must leave every flag and the bus drive untouched. That separates a missing qualification from a correct one. A host read is observed both during the strobe (drive and value) and after it (outbound-full cleared, interrupt raised), which confirms that drive is combinational and that the flags follow the release.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    parameter int unsigned HBP_DATA_W = 8;
    parameter int unsigned HBP_SYNC_STAGES = 2;

    typedef struct packed {
        logic [HBP_DATA_W-1:0] in_byte;
        logic [HBP_DATA_W-1:0] out_byte;
        logic                  in_full;
        logic                  out_full;
        logic                  ovf;
        logic                  irq;
    } hbp_state_t;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/hbp_edge.sv
module hbp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic wr_act,
    input  logic rd_act,
    output logic wr_end,
    output logic rd_end
);
    typedef struct packed {
        logic wr;
        logic rd;
    } prev_t;

    prev_t prev_q, prev_d;
    logic  wr_now, rd_now;

    always_comb begin
        wr_now    = en & wr_act;
        rd_now    = en & rd_act;
        prev_d.wr = wr_now;
        prev_d.rd = rd_now;
        wr_end    = en & prev_q.wr & ~wr_now;
        rd_end    = en & prev_q.rd & ~rd_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/host_byte_port.sv
module host_byte_port
    import hbp_pkg::*;
#(
    parameter int unsigned DATA_W = HBP_DATA_W,
    parameter int unsigned SYNC_STAGES = HBP_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              ext_cs_n,
    input  logic              ext_rd_n,
    input  logic              ext_wr_n,
    input  logic [DATA_W-1:0] ext_data_in,
    output logic [DATA_W-1:0] ext_data_out,
    output logic              ext_data_oe,
    input  logic              cpu_wr_out,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd_in,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              cpu_clr_irq,
    input  logic              cpu_clr_ovf,
    output logic              in_full,
    output logic              out_full,
    output logic              overflow,
    output logic              irq
);
    localparam int unsigned STROBES = 3;

    hbp_state_t st_q, st_d;
    logic [STROBES-1:0] strobe_low, strobe_sync;
    logic wr_act, rd_act, wr_end, rd_end;

    // strobe order: [2] select, [1] write, [0] read
    assign strobe_low = {~ext_cs_n, ~ext_wr_n, ~ext_rd_n};

    hbp_sync #(.WIDTH(STROBES), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(strobe_low), .sync_out(strobe_sync)
    );

    assign wr_act = strobe_sync[2] & strobe_sync[1];
    assign rd_act = strobe_sync[2] & strobe_sync[0];

    hbp_edge edge_i (
        .clk(clk), .rst_n(rst_n), .en(port_en),
        .wr_act(wr_act), .rd_act(rd_act),
        .wr_end(wr_end), .rd_end(rd_end)
    );

    always_comb begin
        st_d = st_q;
        if (cpu_rd_in) st_d.in_full = 1'b0;
        if (wr_end) begin
            st_d.in_byte = ext_data_in[DATA_W-1:0];
            st_d.in_full = 1'b1;
        end
        if (cpu_clr_ovf) st_d.ovf = 1'b0;
        if (wr_end && st_q.in_full && !cpu_rd_in) st_d.ovf = 1'b1;
        if (rd_end) st_d.out_full = 1'b0;
        if (cpu_wr_out) begin
            st_d.out_byte = cpu_wdata;
            st_d.out_full = 1'b1;
        end
        if (cpu_clr_irq) st_d.irq = 1'b0;
        if (wr_end || rd_end) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // bus drive follows the raw strobes so the host sees data inside its strobe
    assign ext_data_oe  = port_en & ~ext_cs_n & ~ext_rd_n;
    assign ext_data_out = st_q.out_byte;
    assign cpu_rdata    = st_q.in_byte;
    assign in_full      = st_q.in_full;
    assign out_full     = st_q.out_full;
    assign overflow     = st_q.ovf;
    assign irq          = st_q.irq;

    // R4
    in_full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end |=> in_full);
    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_end || rd_end) |=> irq);
    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !cpu_clr_ovf) |=> overflow);
    // R7
    out_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && !cpu_wr_out) |=> !out_full);
    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> !(wr_end || rd_end));
    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cpu_clr_irq) |=> irq);
endmodule

// File: tb/host_byte_port_tb_top.sv
module host_byte_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_en = 1'b0;
    logic ext_cs_n = 1'b1, ext_rd_n = 1'b1, ext_wr_n = 1'b1;
    logic [7:0] ext_data_in = '0;
    logic [7:0] ext_data_out;
    logic ext_data_oe;
    logic cpu_wr_out = 1'b0, cpu_rd_in = 1'b0, cpu_clr_irq = 1'b0, cpu_clr_ovf = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic in_full, out_full, overflow, irq;

    always #2.5 clk = ~clk;

    host_byte_port dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en),
        .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_data_in(ext_data_in), .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe),
        .cpu_wr_out(cpu_wr_out), .cpu_wdata(cpu_wdata), .cpu_rd_in(cpu_rd_in),
        .cpu_rdata(cpu_rdata), .cpu_clr_irq(cpu_clr_irq), .cpu_clr_ovf(cpu_clr_ovf),
        .in_full(in_full), .out_full(out_full), .overflow(overflow), .irq(irq)
    );

    typedef struct {
        string      req;
        string      what;
        logic [7:0] val;
    } exp_t;

    exp_t exp_q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // driver side: record what the requirements predict
    task automatic expect_v(input string req, input string what, input logic [7:0] v);
        exp_t e;
        e.req = req; e.what = what; e.val = v;
        exp_q.push_back(e);
    endtask

    // monitor side: pop the oldest prediction and compare with the observed value
    task automatic observe(input logic [7:0] act);
        exp_t e;
        n_vec++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL scoreboard empty: actual %0h expected none", act);
        end else begin
            e = exp_q.pop_front();
            if (act !== e.val) begin
                n_bad++;
                $display("FAIL %s %s: actual %0h expected %0h", e.req, e.what, act, e.val);
            end
        end
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] exp_v,
                       input logic [7:0] act);
        expect_v(req, what, exp_v);
        observe(act);
    endtask

    task automatic flags(input string req, input logic f_in, input logic f_out,
                         input logic f_ovf, input logic f_irq);
        chk(req, "in_full", {7'd0, f_in}, {7'd0, in_full});
        chk(req, "out_full", {7'd0, f_out}, {7'd0, out_full});
        chk(req, "overflow", {7'd0, f_ovf}, {7'd0, overflow});
        chk(req, "irq", {7'd0, f_irq}, {7'd0, irq});
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] d, input logic use_cs);
        @(negedge clk);
        ext_data_in = d;
        ext_cs_n = ~use_cs;
        ext_wr_n = 1'b0;
        wait_n(4);
        ext_wr_n = 1'b1;
        ext_cs_n = 1'b1;
        wait_n(5);
        ext_data_in = 8'hEE;
    endtask

    task automatic cpu_pulse(input int which, input logic [7:0] d);
        @(negedge clk);
        cpu_wdata = d;
        case (which)
            0: cpu_wr_out = 1'b1;
            1: cpu_rd_in = 1'b1;
            2: cpu_clr_irq = 1'b1;
            default: cpu_clr_ovf = 1'b1;
        endcase
        @(negedge clk);
        cpu_wr_out = 1'b0; cpu_rd_in = 1'b0; cpu_clr_irq = 1'b0; cpu_clr_ovf = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        // R1 reset state
        flags("R1", 0, 0, 0, 0);
        chk("R1", "oe", 8'd0, {7'd0, ext_data_oe});
        rst_n = 1'b1;
        wait_n(2);

        // R2 port disabled: strobes ignored
        host_write(8'h11, 1'b1);
        flags("R2", 0, 0, 0, 0);
        @(negedge clk); ext_cs_n = 1'b0; ext_rd_n = 1'b0;
        @(negedge clk);
        chk("R2", "oe while off", 8'd0, {7'd0, ext_data_oe});
        ext_cs_n = 1'b1; ext_rd_n = 1'b1;
        wait_n(5);
        flags("R2", 0, 0, 0, 0);

        port_en = 1'b1;
        wait_n(2);
        // R9 strobes without select
        host_write(8'h22, 1'b0);
        flags("R9", 0, 0, 0, 0);
        @(negedge clk); ext_rd_n = 1'b0;
        @(negedge clk);
        chk("R9", "oe without select", 8'd0, {7'd0, ext_data_oe});
        ext_rd_n = 1'b1;
        wait_n(5);
        flags("R9", 0, 0, 0, 0);

        // R4 host write loads inbound register
        host_write(8'h5A, 1'b1);
        chk("R4", "cpu_rdata", 8'h5A, cpu_rdata);
        flags("R4", 1, 0, 0, 1);
        cpu_pulse(2, 8'h00);
        chk("R8", "irq after clear", 8'd0, {7'd0, irq});

        // R6 second write without acknowledgment
        host_write(8'h33, 1'b1);
        chk("R6", "cpu_rdata", 8'h33, cpu_rdata);
        flags("R6", 1, 0, 1, 1);

        // R5 acknowledgment clears in_full, overflow stays
        cpu_pulse(1, 8'h00);
        flags("R5", 0, 0, 1, 1);
        cpu_pulse(3, 8'h00);
        chk("R6", "overflow after clear", 8'd0, {7'd0, overflow});
        cpu_pulse(2, 8'h00);

        // R7 outbound load
        cpu_pulse(0, 8'hC3);
        flags("R7", 0, 1, 0, 0);

        // R3 host read: drive during the strobe
        @(negedge clk); ext_cs_n = 1'b0; ext_rd_n = 1'b0;
        #1;
        chk("R3", "oe during read", 8'd1, {7'd0, ext_data_oe});
        chk("R3", "bus value", 8'hC3, ext_data_out);
        wait_n(4);
        chk("R7", "out_full during read", 8'd1, {7'd0, out_full});
        ext_cs_n = 1'b1; ext_rd_n = 1'b1;
        #1;
        chk("R3", "oe after read", 8'd0, {7'd0, ext_data_oe});
        wait_n(5);
        // R7 and R8 after the read completes
        flags("R7", 0, 0, 0, 1);

        // R8 clear coinciding with nothing keeps it low; a new write raises it again
        cpu_pulse(2, 8'h00);
        host_write(8'h96, 1'b1);
        chk("R8", "irq after second access", 8'd1, {7'd0, irq});
        chk("R4", "cpu_rdata", 8'h96, cpu_rdata);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule